// File: doc/BRIEF.md
# Readout Word Fetch Through Control Registers

This block lets a control bus pull 24-bit readout words out of the chip through two 16-bit read registers, instead of letting those words leave through the off-chip serial path. It sits in front of two FIFOs that each offer a valid/pop head interface. One FIFO carries busy words and the other carries data words. Busy words always take precedence over data words. A fetch is a pair of register reads. The low register returns bits 15:0 of the head word. The high register then returns bits 23:16 and removes the word from its FIFO.

Register access is in force only while the control-readout mode input is high. While that input is low, the block becomes a plain forwarder. It hands the same two FIFOs, busy first, to a valid/ready stream toward the off-chip path. That stream obeys the usual rules. A word moves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the FIFOs are not popped, and `tx_word` keeps showing the current highest-priority head.

Which FIFO a fetch draws from is captured when the low half is read. A busy word that arrives between the two reads therefore cannot steal the pop from the data word whose low half was already handed out. Register reads are answered one cycle after the request, on `rsp_valid`/`rsp_data`.

Top module: `ctrl_fifo_reader`

## Requirements
- R1: After reset `rsp_valid`, `busy_pop` and `data_pop` are low, and no source is captured, so a high read issued before any low read selects its FIFO by priority.
- R2: With the mode on, a read of address 0x0012 (low register) answers one cycle later with `rsp_valid` high and `rsp_data` equal to bits 15:0 of the selected head word, and pops nothing.
- R3: With the mode on, a read of address 0x0013 (high register) answers one cycle later with `rsp_data` = {8'h00, bits 23:16 of the head}, and it pops exactly one word from the selected FIFO, in the request cycle.
- R4: Whenever the busy FIFO is non-empty, it is the FIFO selected by a low read, by an uncaptured high read, and by the off-chip stream, ahead of the data FIFO. The two FIFOs are never popped in the same cycle.
- R5: A low read captures its source FIFO. The next high read pops and reports that same FIFO, even if a busy word has arrived since.
- R6: A register read with both FIFOs empty returns 0 and pops nothing.
- R7: With the mode off, low and high register reads still answer, but they return 0 and pop nothing. Words are forwarded on `tx_valid`/`tx_word` with busy priority, and a FIFO is popped only in a cycle where `tx_ready` is high.
- R8: With the mode on, `tx_valid` stays low.
- R9: A read request to any address other than 0x0012 or 0x0013 gets no response and pops nothing.
- R10: A high read clears the captured source, and so does turning the mode off. The next high read without a low read then selects by priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| readout_via_ctrl | input | 1 | 1: words fetched through registers; 0: words forwarded off chip |
| rd_en | input | 1 | Register read request strobe |
| rd_addr | input | 16 | Register read address |
| rsp_valid | output | 1 | Read response valid, one cycle after a matching request |
| rsp_data | output | 16 | Read response value |
| busy_valid | input | 1 | Busy FIFO has a head word |
| busy_word | input | 24 | Busy FIFO head word |
| busy_pop | output | 1 | Remove busy FIFO head at this clock edge |
| data_valid | input | 1 | Data FIFO has a head word |
| data_word | input | 24 | Data FIFO head word |
| data_pop | output | 1 | Remove data FIFO head at this clock edge |
| tx_valid | output | 1 | Off-chip stream word available |
| tx_word | output | 24 | Off-chip stream word |
| tx_ready | input | 1 | Off-chip path accepts the word |

## Verification
The assertions assume that each FIFO's `valid` and head word change only at a clock edge. They also assume that a head stays put until the block pops it, so a FIFO can go from non-empty to empty only through this block's own pop. The bench models both FIFOs as queues. It changes them only between clock edges, pushing new words or removing the word popped at the previous edge. It then drives a fixed-seed random mix of pushes, register reads, stray addresses, mode changes and off-chip ready patterns, with directed cases for the empty, priority and capture corners.

// File: rtl/fifo_reg_pkg.sv
package fifo_reg_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned HI_W   = WORD_W - REG_W;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BUSY = 2'd1,
    SRC_DATA = 2'd2
  } src_e;
endpackage

// File: rtl/fifo_prio_pick.sv
module fifo_prio_pick
  import fifo_reg_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         hi_valid,
  input  logic [W-1:0] hi_word,
  input  logic         lo_valid,
  input  logic [W-1:0] lo_word,
  output src_e         pick,
  output logic [W-1:0] pick_word
);
  always_comb begin
    if (hi_valid) begin
      pick      = SRC_BUSY;
      pick_word = hi_word;
    end else if (lo_valid) begin
      pick      = SRC_DATA;
      pick_word = lo_word;
    end else begin
      pick      = SRC_NONE;
      pick_word = '0;
    end
  end
endmodule

// File: rtl/offchip_fwd.sv
module offchip_fwd
  import fifo_reg_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  src_e         pick,
  input  logic [W-1:0] pick_word,
  output logic         tx_valid,
  output logic [W-1:0] tx_word,
  input  logic         tx_ready,
  output logic         pop_busy,
  output logic         pop_data
);
  logic xfer;

  assign tx_valid = enable && (pick != SRC_NONE);
  assign tx_word  = tx_valid ? pick_word : '0;
  assign xfer     = tx_valid && tx_ready;
  assign pop_busy = xfer && (pick == SRC_BUSY);
  assign pop_data = xfer && (pick == SRC_DATA);

  // R7: a forwarded word leaves only on a completed handshake
  assert_fwd_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_busy || pop_data) |-> (tx_valid && tx_ready && enable));
endmodule

// File: rtl/reg_fetch.sv
module reg_fetch
  import fifo_reg_pkg::*;
#(
  parameter int unsigned  W       = WORD_W,
  parameter int unsigned  RW      = REG_W,
  parameter int unsigned  AW      = ADDR_W,
  parameter logic [AW-1:0] LO_ADDR = 16'h0012,
  parameter logic [AW-1:0] HI_ADDR = 16'h0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  src_e          pick,
  input  logic [W-1:0]  pick_word,
  input  logic          busy_valid,
  input  logic [W-1:0]  busy_word,
  input  logic          data_valid,
  input  logic [W-1:0]  data_word,
  output logic          rsp_valid,
  output logic [RW-1:0] rsp_data,
  output logic          pop_busy,
  output logic          pop_data
);
  localparam int unsigned UPW = W - RW;

  logic          lo_req, hi_req, lo_hit, hi_hit;
  src_e          held_src;
  src_e          hi_src;
  logic          hi_has;
  logic [W-1:0]  hi_word;

  assign lo_req = rd_en && (rd_addr == LO_ADDR);
  assign hi_req = rd_en && (rd_addr == HI_ADDR);
  assign lo_hit = lo_req && enable;
  assign hi_hit = hi_req && enable;

  always_comb begin
    hi_src = (held_src != SRC_NONE) ? held_src : pick;
    case (hi_src)
      SRC_BUSY: begin hi_has = busy_valid; hi_word = busy_word; end
      SRC_DATA: begin hi_has = data_valid; hi_word = data_word; end
      default:  begin hi_has = 1'b0;       hi_word = '0;        end
    endcase
  end

  assign pop_busy = hi_hit && hi_has && (hi_src == SRC_BUSY);
  assign pop_data = hi_hit && hi_has && (hi_src == SRC_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_src  <= SRC_NONE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= lo_req || hi_req;
      if (lo_hit) begin
        held_src <= pick;
        rsp_data <= pick_word[RW-1:0];
      end else if (hi_hit) begin
        held_src <= SRC_NONE;
        rsp_data <= hi_has ? {{(2*RW-W){1'b0}}, hi_word[W-1:RW]} : '0;
      end else begin
        if (!enable) held_src <= SRC_NONE;
        rsp_data <= '0;
      end
    end
  end

  // R2: a low-register read never removes a word
  assert_low_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req |-> !(pop_busy || pop_data));
  // R3: the high read answers with a zero upper byte
  assert_high_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_req |=> (rsp_data[RW-1:UPW] == '0));
  // R3: a register pop only takes a word that exists
  assert_pop_has_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_busy -> busy_valid) && (pop_data -> data_valid));
  // R7: with the mode off, register reads answer zero
  assert_off_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !enable) |=> (rsp_data == '0));
  // R9: responses only follow a request to one of the two registers
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_req || hi_req) |=> !rsp_valid);
endmodule

// File: rtl/ctrl_fifo_reader.sv
module ctrl_fifo_reader
  import fifo_reg_pkg::*;
#(
  parameter int unsigned   W       = WORD_W,
  parameter int unsigned   RW      = REG_W,
  parameter int unsigned   AW      = ADDR_W,
  parameter logic [AW-1:0] LO_ADDR = 16'h0012,
  parameter logic [AW-1:0] HI_ADDR = 16'h0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          readout_via_ctrl,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [RW-1:0] rsp_data,
  input  logic          busy_valid,
  input  logic [W-1:0]  busy_word,
  output logic          busy_pop,
  input  logic          data_valid,
  input  logic [W-1:0]  data_word,
  output logic          data_pop,
  output logic          tx_valid,
  output logic [W-1:0]  tx_word,
  input  logic          tx_ready
);
  src_e         pick;
  logic [W-1:0] pick_word;
  logic         reg_pop_busy, reg_pop_data, fwd_pop_busy, fwd_pop_data;

  fifo_prio_pick #(.W(W)) u_pick (
    .hi_valid (busy_valid),
    .hi_word  (busy_word),
    .lo_valid (data_valid),
    .lo_word  (data_word),
    .pick     (pick),
    .pick_word(pick_word)
  );

  reg_fetch #(.W(W), .RW(RW), .AW(AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (readout_via_ctrl),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .pick      (pick),
    .pick_word (pick_word),
    .busy_valid(busy_valid),
    .busy_word (busy_word),
    .data_valid(data_valid),
    .data_word (data_word),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .pop_busy  (reg_pop_busy),
    .pop_data  (reg_pop_data)
  );

  offchip_fwd #(.W(W)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (!readout_via_ctrl),
    .pick     (pick),
    .pick_word(pick_word),
    .tx_valid (tx_valid),
    .tx_word  (tx_word),
    .tx_ready (tx_ready),
    .pop_busy (fwd_pop_busy),
    .pop_data (fwd_pop_data)
  );

  assign busy_pop = readout_via_ctrl ? reg_pop_busy : fwd_pop_busy;
  assign data_pop = readout_via_ctrl ? reg_pop_data : fwd_pop_data;

  // R4: at most one FIFO is popped per cycle
  assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_pop && data_pop));
  // R4: the stream never takes a data word while a busy word waits
  assert_busy_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!readout_via_ctrl && data_pop) |-> !busy_valid);
  // R8: nothing is offered off chip in register mode
  assert_no_tx_in_reg_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    readout_via_ctrl |-> !tx_valid);
endmodule

// File: tb/test_ctrl_fifo_reader.sv
module test_ctrl_fifo_reader;
  logic        clk = 0, rst_n = 0, mode = 0, rd_en = 0, tx_ready = 0;
  logic [15:0] rd_addr = 0;
  logic        rsp_valid, busy_pop, data_pop, tx_valid;
  logic [15:0] rsp_data;
  logic        busy_valid = 0, data_valid = 0;
  logic [23:0] busy_word = 0, data_word = 0, tx_word;

  int n_chk = 0, n_bad = 0;
  logic [23:0] bq[$];
  logic [23:0] dq[$];
  int held = 0;   // 0 none, 1 busy, 2 data
  bit pend_b = 0, pend_d = 0;

  always #5 clk = ~clk;

  ctrl_fifo_reader i_ctrl_fifo_reader (
    .clk(clk), .rst_n(rst_n), .readout_via_ctrl(mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy_valid(busy_valid), .busy_word(busy_word), .busy_pop(busy_pop),
    .data_valid(data_valid), .data_word(data_word), .data_pop(data_pop),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    busy_valid = bq.size() > 0;
    busy_word  = busy_valid ? bq[0] : 24'h0;
    data_valid = dq.size() > 0;
    data_word  = data_valid ? dq[0] : 24'h0;
  endtask

  function automatic int prio();
    if (bq.size() > 0) return 1;
    if (dq.size() > 0) return 2;
    return 0;
  endfunction

  function automatic logic [23:0] head(int s);
    if (s == 1 && bq.size() > 0) return bq[0];
    if (s == 2 && dq.size() > 0) return dq[0];
    return 24'h0;
  endfunction

  function automatic bit has(int s);
    return (s == 1) ? bq.size() > 0 : (s == 2) ? dq.size() > 0 : 1'b0;
  endfunction

  // applied at a falling edge: remove words popped at the previous rising edge
  task automatic settle_pops();
    if (pend_b) void'(bq.pop_front());
    if (pend_d) void'(dq.pop_front());
    pend_b = 0; pend_d = 0;
    refresh();
  endtask

  task automatic push(bit to_busy, logic [23:0] w);
    @(negedge clk);
    if (to_busy) bq.push_back(w); else dq.push_back(w);
    refresh();
  endtask

  task automatic do_read(logic [15:0] a);
    bit lo, hi, exp_rv, eb, ed;
    int s;
    logic [15:0] exp_d;
    @(negedge clk);
    rd_en = 1; rd_addr = a; #1;
    lo = (a == 16'h0012); hi = (a == 16'h0013);
    exp_rv = lo || hi; exp_d = 0; eb = 0; ed = 0;
    if (mode && lo) begin
      s = prio(); exp_d = head(s)[15:0]; held = s;
    end else if (mode && hi) begin
      s = (held != 0) ? held : prio();
      if (has(s)) begin
        exp_d = {8'h00, head(s)[23:16]};
        eb = (s == 1); ed = (s == 2);
      end
      held = 0;
    end
    if (!mode) held = 0;
    chk("R3/R4/R5/R6/R9 busy_pop", busy_pop, eb);
    chk("R3/R4/R5/R6/R9 data_pop", data_pop, ed);
    if (mode) chk("R8 tx_valid", tx_valid, 0);
    pend_b = eb; pend_d = ed;
    @(negedge clk);
    rd_en = 0; rd_addr = 0;
    settle_pops(); #1;
    chk("R2/R9 rsp_valid", rsp_valid, exp_rv);
    if (exp_rv) chk("R2/R3/R6/R7 rsp_data", rsp_data, exp_d);
  endtask

  task automatic tx_step(bit r);
    int s;
    @(negedge clk);
    tx_ready = r; #1;
    s = prio();
    chk("R7 tx_valid", tx_valid, s != 0);
    if (s != 0) chk("R7 R4 tx_word", tx_word, head(s));
    chk("R7 busy_pop", busy_pop, r && s == 1);
    chk("R7 data_pop", data_pop, r && s == 2);
    pend_b = r && s == 1; pend_d = r && s == 2;
    @(negedge clk);
    tx_ready = 0;
    settle_pops();
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    mode = m;
    if (!m) held = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    refresh();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 busy_pop", busy_pop, 0);
    chk("R1 data_pop", data_pop, 0);
    @(negedge clk); rst_n = 1;
    set_mode(1);
    // R6: empty reads
    do_read(16'h0012);
    do_read(16'h0013);
    // R1/R10: high read without a low read picks by priority
    push(0, 24'hA1B2C3);
    push(1, 24'h5E6F70);
    do_read(16'h0013);
    // R2/R3: normal pair on data
    do_read(16'h0012);
    do_read(16'h0013);
    // R5: capture data, busy arrives, high still pops data
    push(0, 24'h123456);
    do_read(16'h0012);
    push(1, 24'hFEDCBA);
    do_read(16'h0013);
    // R4: busy first
    push(0, 24'h0F0F0F);
    do_read(16'h0012);
    do_read(16'h0013);
    // R9: stray addresses
    do_read(16'h0011);
    do_read(16'h0014);
    // R10: capture then mode off clears it
    push(1, 24'h777777);
    do_read(16'h0012);
    set_mode(0);
    // R7: reads in off mode, then forwarding with back-pressure
    do_read(16'h0012);
    do_read(16'h0013);
    tx_step(0);
    tx_step(1);
    tx_step(1);
    tx_step(1);
    set_mode(1);
    do_read(16'h0013);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 15)      push(1, 24'($urandom));
      else if (op < 35) push(0, 24'($urandom));
      else if (op < 60) do_read(16'h0012);
      else if (op < 85) do_read(16'h0013);
      else if (op < 88) do_read(16'($urandom_range(0, 31)));
      else if (op < 91) set_mode(~mode);
      else if (!mode)   tx_step($urandom_range(0, 1) == 1);
      else              do_read(16'h0013);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule